// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between an on-chip requester and an external asynchronous static RAM of 256K words by 4 bits. The requester presents one read or write at a time on a valid/ready port. The controller turns each request into the chip-select, output-enable and write-strobe sequence the RAM needs. It holds the 18-bit address steady for the whole access and drives the 4-bit data lines through an output-enable only while a write pulse is active. For a read, it samples the returned nibble once the access time has passed.

The minimum timing figures of the RAM are parameters in picoseconds, and so is the clock period. At elaboration each figure becomes a whole number of clock cycles, rounded up and never less than one. The write pulse is stretched to cover the pulse width, the data setup and the overall write cycle. The read phase is stretched to cover both the address access time and the read cycle time.

Each access ends with a one-cycle completion pulse. A read leaves its nibble on the result port until the next read finishes. Between accesses all strobes are inactive (high), so the RAM sits in standby with its pins floating.

Top module: `sram_async_ctrl`

## Requirements
- R1: While no access is in flight, `req_ready` is 1, the three strobes `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0 and `done` is 0. The same holds during reset, and `rdata` resets to 0.
- R2: `mem_we_n` is 0 only while `mem_ce_n` is 0 and `mem_oe_n` is 1. `mem_oe_n` stays 1 for every cycle of a write.
- R3: `mem_dq_oe` is 1 exactly in the cycles where `mem_we_n` is 0, and only if `mem_oe_n` was 1 in the previous cycle as well. The data lines are never driven while `mem_oe_n` is 0.
- R4: A read holds `mem_ce_n` at 0, `mem_oe_n` at 0 and `mem_we_n` at 1, with `mem_dq_oe` at 0.
- R5: The write pulse (`mem_we_n` at 0) lasts exactly WP cycles, and `mem_dq_o` carries the request's data, unchanged, for the whole pulse.
- R6: The read phase (`mem_oe_n` at 0) lasts exactly RD cycles. `rdata` takes the value of `mem_dq_i` sampled at the clock edge that ends that phase.
- R7: `mem_addr` equals the accepted request's address and stays unchanged in every cycle where `mem_ce_n` is 0.
- R8: `done` is high for exactly one cycle per access. For a write it is high in the cycle after the pulse, with `mem_ce_n` still 0 and `mem_we_n` at 1. For a read it is high in the cycle after the read phase, with all strobes at 1.
- R9: `rdata` changes only at the end of a read phase, and holds its value through writes and idle cycles.
- R10: A write has three phases in order: one setup cycle with `mem_ce_n` at 0 and `mem_we_n` at 1, then the pulse, then the completion cycle. A read starts with the read phase directly.
- R11: `req_ready` is 1 only when idle. A request is accepted in a cycle with `req_valid` and `req_ready` both at 1, and `mem_ce_n` goes to 0 in the next cycle.
- R12: Cycle counts are ceil(t/clock), with a minimum of 1. RD is the larger of the counts for the read access time and the read cycle time. WP is the largest of three counts: the write pulse width, the data setup time, and the write cycle time minus 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 4 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 4 | Last read result |
| mem_addr | output | 18 | RAM address bus |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_dq_o | output | 4 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Tristate enable for `mem_dq_o` |
| mem_dq_i | input | 4 | Data returned from the RAM pads |

## Verification
The bench's memory model returns inverted data until the read phase has lasted RD cycles. A controller that samples one cycle early therefore returns a wrong nibble. The model stores a write only if the pulse lasted WP cycles with the driver on, so a pulse that is too short or a driver that switches on late shows up on a later read of the same address. Requests held valid across busy cycles, back-to-back accesses and the address extremes 0 and 0x3FFFF check two things. A controller that accepted while busy would break the per-cycle strobe comparison, and one that let the address move mid-access would break it too. Any drive of the data lines while output enable is low is flagged as contention, and so is any change of `rdata` outside a read completion.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [5:0] {
    ST_IDLE = 6'b000001,
    ST_WSET = 6'b000010,
    ST_WPUL = 6'b000100,
    ST_WEND = 6'b001000,
    ST_RACC = 6'b010000,
    ST_REND = 6'b100000
  } seq_state_t;

  function automatic int unsigned wait_cycles(input int unsigned t_ps,
                                              input int unsigned clk_ps);
    int unsigned c;
    if (clk_ps == 0) return 1;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned read_cycles(input int unsigned t_aa, input int unsigned t_rc,
                                              input int unsigned clk_ps);
    return max_u(wait_cycles(t_aa, clk_ps), wait_cycles(t_rc, clk_ps));
  endfunction

  // Pulse covers width and data setup; setup and completion cycles add two to the write cycle.
  function automatic int unsigned pulse_cycles(input int unsigned t_wp, input int unsigned t_ds,
                                               input int unsigned t_wc, input int unsigned clk_ps);
    int unsigned wc;
    int unsigned rest;
    wc   = wait_cycles(t_wc, clk_ps);
    rest = (wc > 2) ? wc - 2 : 1;
    return max_u(max_u(wait_cycles(t_wp, clk_ps), wait_cycles(t_ds, clk_ps)), rest);
  endfunction

  function automatic int unsigned count_width(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) <= n) w++;
    return w;
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign last = (cnt == CNT_W'(1));
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC = 2,
  parameter int unsigned WP_CYC = 2,
  parameter int unsigned CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_we,
  input  logic             timer_last,
  output seq_state_t       state,
  output logic             accept,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val,
  output logic             capture,
  output logic             pulse_end
);
  seq_state_t nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (req_valid) nxt = req_we ? ST_WSET : ST_RACC;
      ST_WSET: nxt = ST_WPUL;
      ST_WPUL: if (timer_last) nxt = ST_WEND;
      ST_WEND: nxt = ST_IDLE;
      ST_RACC: if (timer_last) nxt = ST_REND;
      ST_REND: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  assign accept     = (state == ST_IDLE) && req_valid;
  assign timer_load = (accept && !req_we) || (state == ST_WSET);
  assign timer_val  = (state == ST_WSET) ? CNT_W'(WP_CYC) : CNT_W'(RD_CYC);
  assign capture    = (state == ST_RACC) && timer_last;
  assign pulse_end  = (state == ST_WPUL) && timer_last;
endmodule

// File: rtl/sram_pin_unit.sv
module sram_pin_unit
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_t        state,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= mem_dq_i;
  end

  // Strobes decode single one-hot state bits.
  assign mem_ce_n  = !(state == ST_WSET || state == ST_WPUL ||
                       state == ST_WEND || state == ST_RACC);
  assign mem_oe_n  = (state != ST_RACC);
  assign mem_we_n  = (state != ST_WPUL);
  assign mem_dq_oe = (state == ST_WPUL);
  assign mem_dq_o  = wdata_q;
  assign mem_addr  = addr_q;
  assign rdata     = rdata_q;
  assign done      = (state == ST_WEND) || (state == ST_REND);
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W       = 18,
  parameter int unsigned DATA_W       = 4,
  parameter int unsigned CLK_PERIOD_PS = 5000,
  parameter int unsigned T_AA_PS      = 10000,
  parameter int unsigned T_RC_PS      = 10000,
  parameter int unsigned T_WP_PS      = 9000,
  parameter int unsigned T_DS_PS      = 7000,
  parameter int unsigned T_WC_PS      = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int unsigned RD_CYC = read_cycles(T_AA_PS, T_RC_PS, CLK_PERIOD_PS);
  localparam int unsigned WP_CYC = pulse_cycles(T_WP_PS, T_DS_PS, T_WC_PS, CLK_PERIOD_PS);
  localparam int unsigned CNT_W  = count_width(max_u(RD_CYC, WP_CYC));

  seq_state_t       state;
  logic             acc_start;
  logic             rd_capture;
  logic             wr_pulse_end;
  logic             timer_load;
  logic [CNT_W-1:0] timer_val;
  logic             timer_last;

  sram_seq_fsm #(.RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_we     (req_we),
    .timer_last (timer_last),
    .state      (state),
    .accept     (acc_start),
    .timer_load (timer_load),
    .timer_val  (timer_val),
    .capture    (rd_capture),
    .pulse_end  (wr_pulse_end)
  );

  sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .last     (timer_last)
  );

  sram_pin_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .accept    (acc_start),
    .capture   (rd_capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_dq_i  (mem_dq_i),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe),
    .rdata     (rdata),
    .done      (done)
  );

  assign req_ready = (state == ST_IDLE);
endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 4,
  parameter int unsigned RD_CYC = 2,
  parameter int unsigned WP_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              done,
  input logic [DATA_W-1:0] rdata,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe,
  input logic              acc_start,
  input logic              rd_capture,
  input logic              wr_pulse_end
);
  int unsigned we_low_cnt;
  int unsigned oe_low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt <= 0;
      oe_low_cnt <= 0;
    end else begin
      we_low_cnt <= mem_we_n ? 0 : we_low_cnt + 1;
      oe_low_cnt <= mem_oe_n ? 0 : oe_low_cnt + 1;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !done));
  a_r2_write_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));
  a_r3_drive_gate: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n && $past(mem_oe_n)));
  a_r3_drive_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);
  a_r4_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n && !mem_dq_oe));
  a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt == WP_CYC));
  a_r5_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_dq_o));
  a_r5_pulse_end_rise: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse_end |=> (mem_we_n && done));
  a_r6_access_time: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_low_cnt == RD_CYC));
  a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> $past(rd_capture));
  a_r10_setup_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(mem_ce_n) == 1'b0));
  a_r11_start: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |=> !mem_ce_n);
endmodule

bind sram_async_ctrl sram_ctrl_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_CYC(RD_CYC), .WP_CYC(WP_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done), .rdata(rdata),
  .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .acc_start(acc_start),
  .rd_capture(rd_capture), .wr_pulse_end(wr_pulse_end)
);

// File: tb/test_sram_async_ctrl.sv
`timescale 1ps/1ps
module test_sram_async_ctrl;
  localparam int CLK_PS = 5000;

  typedef struct packed {
    logic        ce_n;
    logic        oe_n;
    logic        we_n;
    logic        dq_oe;
    logic        done;
    logic        rd_done;
    logic [17:0] addr;
    logic [3:0]  wdata;
  } cyc_t;

  function automatic int span(input int t);
    int n = 0;
    int acc = 0;
    while (acc < t) begin acc += CLK_PS; n++; end
    if (n < 1) n = 1;
    return n;
  endfunction

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  int nrd, nwp;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0;
  logic [17:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic req_ready, done, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [3:0] rdata, mem_dq_o;
  logic [3:0] mem_dq_i = 4'h5;
  logic [17:0] mem_addr;

  always #(CLK_PS/2) clk = ~clk;

  sram_async_ctrl #(.CLK_PERIOD_PS(CLK_PS)) i_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .done(done),
    .rdata(rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  cyc_t exp_q[$];
  logic [3:0] rd_q[$];
  logic [3:0] exp_mem [logic [17:0]];
  logic [3:0] pin_mem [logic [17:0]];
  logic [3:0] last_rdata = 4'h0;
  logic prev_oe_n = 1'b1;
  int rd_age = 0;
  logic prev_rd = 0;
  logic [17:0] prev_rd_addr = '0;
  int wlow = 0;
  logic [17:0] w_addr;
  logic [3:0] w_data;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [3:0] pin_read(input logic [17:0] a);
    return pin_mem.exists(a) ? pin_mem[a] : 4'h0;
  endfunction

  // Memory model: acts on pins seen during the current cycle.
  task automatic mem_model();
    logic rd;
    rd = !mem_ce_n && !mem_oe_n && mem_we_n;
    if (rd && prev_rd && mem_addr == prev_rd_addr) rd_age++;
    else rd_age = 0;
    prev_rd = rd;
    prev_rd_addr = mem_addr;
    if (rd) mem_dq_i = (rd_age >= nrd - 1) ? pin_read(mem_addr) : ~pin_read(mem_addr);
    else    mem_dq_i = 4'h5;
    // R3 contention check
    check(!(mem_dq_oe && !mem_oe_n), "R3 contention dq_oe with oe_n low", {31'd0, mem_dq_oe}, 0);
    if (!mem_we_n && !mem_ce_n) begin
      if (wlow == 0) begin w_addr = mem_addr; w_data = mem_dq_o; end
      if (!mem_dq_oe || mem_dq_o != w_data || mem_addr != w_addr) wlow = -1000;
      wlow++;
    end else if (wlow != 0) begin
      if (wlow >= nwp) pin_mem[w_addr] = w_data;
      wlow = 0;
    end
  endtask

  task automatic step();
    cyc_t e;
    bit busy;
    @(negedge clk);
    mem_model();
    busy = (exp_q.size() != 0);
    if (busy) e = exp_q.pop_front();
    else e = '{ce_n:1, oe_n:1, we_n:1, dq_oe:0, done:0, rd_done:0, addr:'0, wdata:'0};
    check(req_ready == !busy, "R11 ready", {31'd0, req_ready}, {31'd0, !busy});
    if (!busy)
      check({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, done} == 5'b11100, "R1 idle strobes",
            {27'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, done}, 32'b11100);
    else begin
      check({mem_ce_n, mem_oe_n, mem_we_n} == {e.ce_n, e.oe_n, e.we_n},
            "R2 R4 R10 R12 strobe sequence", {29'd0, mem_ce_n, mem_oe_n, mem_we_n},
            {29'd0, e.ce_n, e.oe_n, e.we_n});
      check(mem_dq_oe == e.dq_oe, "R3 driver enable", {31'd0, mem_dq_oe}, {31'd0, e.dq_oe});
      check(done == e.done, "R8 done pulse", {31'd0, done}, {31'd0, e.done});
      if (!e.ce_n) check(mem_addr == e.addr, "R7 address", {14'd0, mem_addr}, {14'd0, e.addr});
      if (e.dq_oe) check(mem_dq_o == e.wdata, "R5 write data", {28'd0, mem_dq_o}, {28'd0, e.wdata});
      if (e.dq_oe) check(prev_oe_n, "R3 oe high before drive", {31'd0, prev_oe_n}, 1);
    end
    if (busy && e.rd_done) begin
      logic [3:0] x;
      x = rd_q.pop_front();
      check(rdata == x, "R6 read data", {28'd0, rdata}, {28'd0, x});
      last_rdata = x;
    end else begin
      check(rdata == last_rdata, "R9 rdata hold", {28'd0, rdata}, {28'd0, last_rdata});
    end
    prev_oe_n = mem_oe_n;
  endtask

  task automatic push_access(input bit we, input logic [17:0] a, input logic [3:0] d);
    cyc_t c;
    c = '{ce_n:0, oe_n:1, we_n:1, dq_oe:0, done:0, rd_done:0, addr:a, wdata:d};
    if (we) begin
      exp_q.push_back(c);
      for (int i = 0; i < nwp; i++) begin
        c.we_n = 0; c.dq_oe = 1; exp_q.push_back(c);
      end
      c.we_n = 1; c.dq_oe = 0; c.done = 1; exp_q.push_back(c);
      exp_mem[a] = d;
    end else begin
      for (int i = 0; i < nrd; i++) begin
        c.oe_n = 0; exp_q.push_back(c);
      end
      c = '{ce_n:1, oe_n:1, we_n:1, dq_oe:0, done:1, rd_done:1, addr:a, wdata:'0};
      exp_q.push_back(c);
      rd_q.push_back(exp_mem.exists(a) ? exp_mem[a] : 4'h0);
    end
  endtask

  // Holds the request valid until accepted; leaves it asserted for back-to-back use.
  task automatic issue(input bit we, input logic [17:0] a, input logic [3:0] d);
    bit acc;
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    forever begin
      acc = req_ready;
      if (acc) push_access(we, a, d);
      step();
      if (acc) break;
    end
  endtask

  task automatic idle(input int n);
    req_valid = 0;
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    nrd = maxi(span(10000), span(10000));
    nwp = maxi(maxi(span(9000), span(7000)), span(10000) - 2);
    if (nwp < 1) nwp = 1;
    // R1 reset state
    repeat (3) begin
      @(negedge clk);
      check({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, done} == 5'b11100, "R1 reset strobes",
            {27'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, done}, 32'b11100);
      check(rdata == 4'h0, "R1 reset rdata", {28'd0, rdata}, 0);
    end
    rst_n = 1;
    idle(2);
    // Address extremes, write then read back (R5 R6 R7)
    issue(1, 18'h00000, 4'hA); idle(1);
    issue(1, 18'h3FFFF, 4'h3); idle(1);
    issue(0, 18'h00000, 4'h0); idle(1);
    issue(0, 18'h3FFFF, 4'h0); idle(2);
    // Unwritten address reads 0, then back-to-back with valid held (R11)
    issue(0, 18'h12345, 4'h0);
    issue(1, 18'h15555, 4'h9);
    issue(0, 18'h15555, 4'h0);
    issue(1, 18'h15555, 4'h6);
    issue(0, 18'h3FFFF, 4'h0);
    issue(0, 18'h15555, 4'h0);
    idle(3);
    // Writes between reads keep rdata (R9)
    issue(1, 18'h00001, 4'hF);
    idle(4);
    // Mixed traffic over a small address set
    for (int k = 0; k < 300; k++) begin
      logic [17:0] a;
      int sel;
      sel = $urandom_range(0, 5);
      a = (sel == 0) ? 18'h0 : (sel == 1) ? 18'h3FFFF : (sel == 2) ? 18'h2AAAA :
          18'(sel);
      issue($urandom_range(0, 1) == 1, a, 4'($urandom_range(0, 15)));
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
    end
    idle(8);
    check(exp_q.size() == 0, "R8 all accesses completed", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule